// File: doc/BRIEF.md
# Prioritized interrupt level acceptor

This block is the external interrupt intake of a processor. An external device pulls an active-low request line and presents a 4-bit priority code. On every clock edge where the request is low, the block copies the code into an internal code register. In the following cycle it compares that stored code against the current mask level. Code 0001 is the most urgent external interrupt and 1111 the least urgent. A stored code qualifies when it is non-zero and numerically no greater than the mask level.

A qualifying code produces a one-cycle start pulse for the interrupt sequence, together with the accepted level. The same edge lowers the mask to one below the accepted level, so a request that is still held is not taken again. A code that does not qualify is ignored for that cycle. It is sampled and compared again on every later cycle for as long as the request stays low, and it is taken once software writes a mask level that admits it. Software writes the mask through a strobe and a value. The context switch and the vector fetch are outside this block.

Top module: `irq_level_accept`

## Requirements
- R1: While rst_ni is low, and just after it is released, start_o is 0, level_o is 0 and mask_o equals the reset mask (all ones, 4'b1111, by default).
- R2: A code present on code_i at a rising edge where req_ni is 0 is stored. If it qualifies, start_o is high after the second rising edge from that sample: one edge stores the code, the next edge registers the pulse.
- R3: A stored code qualifies when it is non-zero and code <= mask_o. On acceptance, start_o is high for that cycle and level_o equals the accepted code. Code 4'b0001 is therefore admitted by every non-zero mask.
- R4: A stored code with code > mask_o produces no pulse. If req_ni stays 0 and software later writes a mask >= code, the request is accepted on the resampled code.
- R5: On the edge that raises start_o, mask_o becomes the accepted level minus one, unless a software write lands on the same edge.
- R6: On a rising edge with mask_wr_i = 1, mask_o takes mask_i. A software write takes priority over the automatic lowering of R5.
- R7: Code 4'b0000 is never accepted, whatever the mask.
- R8: level_o keeps the last accepted level until the next acceptance.
- R9: While req_ni is 1, no new code is stored and nothing presented on code_i leads to a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | External interrupt request, active low |
| code_i | input | 4 | Interrupt priority code, bit 3 is the MSB, 0001 is the highest priority |
| mask_wr_i | input | 1 | Strobe that loads a new mask level |
| mask_i | input | 4 | Mask level loaded by the strobe |
| start_o | output | 1 | One-cycle pulse that starts the interrupt sequence |
| level_o | output | 4 | Level of the most recent accepted interrupt |
| mask_o | output | 4 | Current mask level |

## Verification
The hardest case to reach from the ports is a request that is rejected, stays held, and is later accepted only because a software write raises the mask. A close second is a software write that lands on the same edge as an acceptance, which must override the automatic lowering. Directed sequences hold a request across several rejected cycles before writing a mask that admits it. They also strobe a mask write every cycle while a low code is held, so that writes and acceptances coincide. Random stimulus with a biased active request and sparse mask writes then mixes these situations with code changes in the middle of a hold, the zero code and released requests.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  parameter int unsigned IRQ_CODE_W = 4;

  typedef enum logic [1:0] {
    MSRC_HOLD = 2'd0,
    MSRC_SW   = 2'd1,
    MSRC_AUTO = 2'd2
  } mask_src_e;
endpackage

// File: rtl/irq_code_sampler.sv
module irq_code_sampler #(
  parameter int unsigned CODE_W = irq_accept_pkg::IRQ_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              pend_o,
  output logic [CODE_W-1:0] code_o
);
  logic              pend_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= '0;
    end else begin
      pend_q <= ~req_ni;
      if (!req_ni) code_q <= code_i;
    end
  end

  assign pend_o = pend_q;
  assign code_o = code_q;
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
  parameter int unsigned CODE_W    = irq_accept_pkg::IRQ_CODE_W,
  parameter bit          ZERO_IDLE = 1'b1
) (
  input  logic              pend_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] mask_i,
  output logic              admit_o
);
  logic within_mask;
  assign within_mask = (code_i <= mask_i);

  generate
    if (ZERO_IDLE) begin : g_zero_idle
      assign admit_o = pend_i && (code_i != '0) && within_mask;
    end else begin : g_zero_live
      assign admit_o = pend_i && within_mask;
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned        CODE_W     = irq_accept_pkg::IRQ_CODE_W,
  parameter logic [CODE_W-1:0]  RESET_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] wr_val_i,
  input  logic              admit_i,
  input  logic [CODE_W-1:0] level_i,
  output logic [CODE_W-1:0] mask_o
);
  import irq_accept_pkg::*;

  mask_src_e         src;
  logic [CODE_W-1:0] mask_q, mask_d;

  always_comb begin
    if (wr_i)         src = MSRC_SW;   // software wins
    else if (admit_i) src = MSRC_AUTO;
    else              src = MSRC_HOLD;
  end

  always_comb begin
    unique case (src)
      MSRC_SW:   mask_d = wr_val_i;
      MSRC_AUTO: mask_d = level_i - CODE_W'(1);
      default:   mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RESET_MASK;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_grant_reg.sv
module irq_grant_reg #(
  parameter int unsigned CODE_W = irq_accept_pkg::IRQ_CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              admit_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              start_o,
  output logic [CODE_W-1:0] level_o
);
  logic              start_q;
  logic [CODE_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      level_q <= '0;
    end else begin
      start_q <= admit_i;
      if (admit_i) level_q <= code_i;
    end
  end

  assign start_o = start_q;
  assign level_o = level_q;
endmodule

// File: rtl/irq_level_accept.sv
module irq_level_accept #(
  parameter int unsigned       CODE_W     = irq_accept_pkg::IRQ_CODE_W,
  parameter logic [CODE_W-1:0] RESET_MASK = '1,
  parameter bit                ZERO_IDLE  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              mask_wr_i,
  input  logic [CODE_W-1:0] mask_i,
  output logic              start_o,
  output logic [CODE_W-1:0] level_o,
  output logic [CODE_W-1:0] mask_o
);
  logic              pend;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] mask_q;
  logic              admit;

  irq_code_sampler #(.CODE_W(CODE_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .code_i (code_i),
    .pend_o (pend),
    .code_o (code_q)
  );

  irq_qualifier #(.CODE_W(CODE_W), .ZERO_IDLE(ZERO_IDLE)) u_qual (
    .pend_i  (pend),
    .code_i  (code_q),
    .mask_i  (mask_q),
    .admit_o (admit)
  );

  irq_mask_reg #(.CODE_W(CODE_W), .RESET_MASK(RESET_MASK)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mask_wr_i),
    .wr_val_i (mask_i),
    .admit_i  (admit),
    .level_i  (code_q),
    .mask_o   (mask_q)
  );

  irq_grant_reg #(.CODE_W(CODE_W)) u_grant (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .admit_i (admit),
    .code_i  (code_q),
    .start_o (start_o),
    .level_o (level_o)
  );

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_accept_chk.sv
module irq_level_accept_chk #(
  parameter int unsigned CODE_W = irq_accept_pkg::IRQ_CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              mask_wr_i,
  input logic [CODE_W-1:0] mask_i,
  input logic              start_o,
  input logic [CODE_W-1:0] level_o,
  input logic [CODE_W-1:0] mask_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= 2'd0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_nonzero_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (level_o != '0));

  assert_admit_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && start_o) |-> (level_o <= $past(mask_o)));

  assert_auto_lower_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && start_o && !$past(mask_wr_i)) |-> (mask_o == CODE_W'(level_o - CODE_W'(1))));

  assert_sw_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $past(mask_wr_i)) |-> (mask_o == $past(mask_i)));

  assert_req_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2 && start_o) |-> !$past(req_ni, 2));

  assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && !start_o) |-> $stable(level_o));
endmodule

bind irq_level_accept irq_level_accept_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/irq_level_accept_test.sv
module irq_level_accept_test;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_ni = 1'b1;
  logic [W-1:0] code_i = '0;
  logic         mask_wr_i = 1'b0;
  logic [W-1:0] mask_i = '0;
  logic         start_o;
  logic [W-1:0] level_o, mask_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  bit         m_pend = 0;
  bit [W-1:0] m_code = 0;
  bit [W-1:0] m_mask = '1;
  bit         m_start = 0;
  bit [W-1:0] m_level = 0;

  always #4 clk_i = ~clk_i;

  irq_level_accept uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(req_ni), .code_i(code_i),
    .mask_wr_i(mask_wr_i), .mask_i(mask_i),
    .start_o(start_o), .level_o(level_o), .mask_o(mask_o)
  );

  function automatic bit admits(bit pend, bit [W-1:0] c, bit [W-1:0] m);
    return pend && (c != 0) && (c <= m);
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rq, bit [W-1:0] c, bit wr, bit [W-1:0] mv);
    bit adm;
    @(negedge clk_i);
    req_ni = ~rq; code_i = c; mask_wr_i = wr; mask_i = mv;
    @(posedge clk_i);
    adm = admits(m_pend, m_code, m_mask);
    m_start = adm;
    if (adm) m_level = m_code;
    if (wr) m_mask = mv;
    else if (adm) m_mask = m_code - 1;
    m_pend = rq;
    if (rq) m_code = c;
    #1;
    check(tag, "start_o", {3'b0, start_o}, {3'b0, m_start});
    check("R8", "level_o", level_o, m_level);
    check("R5", "mask_o", mask_o, m_mask);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", "start_o", {3'b0, start_o}, 4'h0);
    check("R1", "level_o", level_o, 4'h0);
    check("R1", "mask_o", mask_o, 4'hF);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", "mask_o after release", mask_o, 4'hF);

    // R9: released request ignores code
    for (int i = 0; i < 4; i++) step("R9", 0, 4'h1, 0, 0);
    // R7: zero code never accepted
    for (int i = 0; i < 4; i++) step("R7", 1, 4'h0, 0, 0);
    // R2: accept timing, then held request blocked by lowered mask
    for (int i = 0; i < 5; i++) step("R2", 1, 4'h5, 0, 0);
    // R4: rejected until mask raised
    step("R4", 1, 4'h5, 1, 4'h3);
    for (int i = 0; i < 3; i++) step("R4", 1, 4'h5, 0, 0);
    step("R4", 1, 4'h5, 1, 4'h5);
    for (int i = 0; i < 4; i++) step("R4", 1, 4'h5, 0, 0);
    // R6: write coincides with acceptance each cycle
    for (int i = 0; i < 5; i++) step("R6", 1, 4'h2, 1, 4'h9);
    // R3: highest priority at smallest non-zero mask
    step("R3", 0, 4'h0, 1, 4'h1);
    for (int i = 0; i < 5; i++) step("R3", 1, 4'h1, 0, 0);
    // R3: lowest priority with full mask
    step("R3", 0, 4'h0, 1, 4'hF);
    for (int i = 0; i < 3; i++) step("R3", 1, 4'hF, 0, 0);
    step("R9", 0, 4'h3, 0, 0);
    step("R9", 0, 4'h3, 0, 0);

    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 4000; i++) begin
      bit rq = ($urandom % 4) != 0;
      bit wr = ($urandom % 10) == 0;
      step("R3", rq, W'($urandom), wr, W'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule